// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Decoder

This block turns three clock-synchronous Hall-sensor levels into six gate enables for a three-phase half-bridge set. Each phase has a high-side and a low-side enable. A direction select, an active-low brake, a stop input and a high-side chopping gate from a separate duty modulator steer the result.

In normal running the Hall code picks one high-side switch and one low-side switch on two different phases. Only the high side is gated by the chopping input. The direction select inverts the Hall code before the lookup.

When the requested pattern would turn on a switch whose partner on the same phase is on now, the block first drives every switch off for a parameterised dead time. Only then does it apply the new pattern. This covers a direction flip and brake entry or exit. Ordinary commutation steps never pair switches on one phase this way, so they are applied at once.

None of the interfaces carries a data stream, so there is no valid/ready handshake. Every pin is a plain level, sampled on each rising clock edge.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_i`=0, `brake_n_i`=1, `stop_i`=0 and `pwm_i`=1, the Hall code {IN1,IN2,IN3} = `hall_i[2:0]` maps to these enable pairs, with bit 0 = phase U, bit 1 = V and bit 2 = W on both output buses: 101→V high + U low, 100→W high + U low, 110→W high + V low, 010→U high + V low, 011→U high + W low, 001→V high + W low.
- R2: With `dir_i`=1, the Hall code is bit-inverted before the R1 lookup. For example, 010 gives V high + U low and 011 gives W high + U low.
- R3: During normal running `pwm_i`=0 clears the high-side enable. The low-side enable of the active pair stays on.
- R4: Hall codes 000 and 111 turn all six enables off.
- R5: `brake_n_i`=0 turns all three high-side enables on and all three low-side enables off. The brake pattern is not gated by `pwm_i`.
- R6: `stop_i`=1 turns all six enables off and overrides the brake.
- R7: The brake overrides the Hall code, including the invalid codes.
- R8: A transition that would turn on a switch whose same-phase partner is currently on first produces all-off outputs. The outputs read all-off from the 2nd through the (DEAD_CYC+2)th rising edge after the input change, and the new pattern appears at edge DEAD_CYC+3. On no phase do both enables come on together, and a high-side enable never comes on in the cycle right after its low-side partner was on, or the reverse.
- R9: A change with no such conflict reaches the outputs on the 2nd rising edge after the input change. There is no off gap, and the old pattern is still shown after the 1st edge.
- R10: While `rst_n` is low, all six enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_i | input | 3 | Synchronized Hall levels, bit 2 = IN1, bit 0 = IN3 |
| dir_i | input | 1 | Direction select, 1 inverts the Hall code |
| brake_n_i | input | 1 | Active-low short-circuit brake |
| stop_i | input | 1 | Forces all enables off when high |
| pwm_i | input | 1 | High-side chopping gate, 1 = conduct |
| hi_en_o | output | 3 | High-side enables, bit 0 = U, 1 = V, 2 = W |
| lo_en_o | output | 3 | Low-side enables, bit 0 = U, 1 = V, 2 = W |

## Verification
The dead-time window is the hardest case to reach, because no legal forward commutation step ever triggers it. The stimulus reaches it in three ways. It first settles on a driving pattern and then flips the direction while holding the same Hall code, so the two phases exchange sides. It also enters the brake from a pattern with a low-side switch on, and it leaves the brake back to such a pattern. In each case the outputs are sampled at the last off cycle and at the first cycle with the new pattern. This pins down the exact window length in both directions.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int unsigned NPH = 3;

  typedef struct packed {
    logic [NPH-1:0] hi;
    logic [NPH-1:0] lo;
  } drive_t;

  localparam drive_t DRV_OFF = '{hi: '0, lo: '0};
endpackage

// File: rtl/hc_lookup.sv
module hc_lookup
  import hc_pkg::*;
(
  input  logic [NPH-1:0] hall_i,
  input  logic           dir_i,
  input  logic           brake_n_i,
  input  logic           stop_i,
  output drive_t         tgt_o
);
  logic [NPH-1:0] code;

  // Reverse running is expressed as a per-bit inversion of the sensor code.
  for (genvar b = 0; b < NPH; b++) begin : g_inv
    assign code[b] = hall_i[b] ^ dir_i;
  end

  drive_t comm;

  always_comb begin
    unique case (code)
      3'b101:  comm = '{hi: 3'b010, lo: 3'b001};
      3'b100:  comm = '{hi: 3'b100, lo: 3'b001};
      3'b110:  comm = '{hi: 3'b100, lo: 3'b010};
      3'b010:  comm = '{hi: 3'b001, lo: 3'b010};
      3'b011:  comm = '{hi: 3'b001, lo: 3'b100};
      3'b001:  comm = '{hi: 3'b010, lo: 3'b100};
      default: comm = DRV_OFF;
    endcase
  end

  // Priority: stop, then brake, then commutation.
  always_comb begin
    if (stop_i)          tgt_o = DRV_OFF;
    else if (!brake_n_i) tgt_o = '{hi: '1, lo: '0};
    else                 tgt_o = comm;
  end
endmodule

// File: rtl/hc_interlock.sv
module hc_interlock
  import hc_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  drive_t tgt_i,
  output drive_t cur_o
);
  localparam int unsigned CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

  drive_t        cur;
  logic [CW-1:0] cnt;
  logic          clash;

  // A leg clashes when the target turns on the partner of a switch that is on now.
  assign clash = |((tgt_i.hi & cur.lo) | (tgt_i.lo & cur.hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= DRV_OFF;
      cnt <= '0;
    end else if (cnt != '0) begin
      cur <= DRV_OFF;
      cnt <= cnt - 1'b1;
    end else if (clash) begin
      cur <= DRV_OFF;
      cnt <= CW'(DEAD_CYC);
    end else begin
      cur <= tgt_i;
    end
  end

  assign cur_o = cur;

  // R8: the applied pattern never hands a leg straight from one switch to its partner.
  a_r8_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur.hi & $past(cur.lo)) == '0) && ((cur.lo & $past(cur.hi)) == '0));

  // R8: while the dead-time counter runs, nothing is applied.
  a_r8_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0) |-> (cur == DRV_OFF));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       brake_n_i,
  input  logic       stop_i,
  input  logic       pwm_i,
  output logic [2:0] hi_en_o,
  output logic [2:0] lo_en_o
);
  drive_t tgt;
  drive_t cur;
  logic   brake_pat;

  hc_lookup u_lookup (
    .hall_i    (hall_i),
    .dir_i     (dir_i),
    .brake_n_i (brake_n_i),
    .stop_i    (stop_i),
    .tgt_o     (tgt)
  );

  hc_interlock #(.DEAD_CYC(DEAD_CYC)) u_interlock (
    .clk   (clk),
    .rst_n (rst_n),
    .tgt_i (tgt),
    .cur_o (cur)
  );

  // All three high sides on can only be the brake pattern; it is never chopped.
  assign brake_pat = &cur.hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_en_o <= '0;
      lo_en_o <= '0;
    end else begin
      hi_en_o <= cur.hi & {NPH{pwm_i | brake_pat}};
      lo_en_o <= cur.lo;
    end
  end

  // R8: no phase ever has both switches enabled.
  a_r8_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en_o & lo_en_o) == '0);

  // R6: two edges after stop is seen, every enable is low.
  a_r6_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_i, 2) |-> (hi_en_o == '0 && lo_en_o == '0));

  // R4: an invalid code without brake or stop leads to all-off.
  a_r4_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past((hall_i == 3'b000 || hall_i == 3'b111) && brake_n_i && !stop_i, 2)
      |-> (hi_en_o == '0 && lo_en_o == '0));

  // R1: at most one low side, and one high side unless braking.
  a_r1_pair_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_en_o) && ($onehot0(hi_en_o) || hi_en_o == 3'b111));

  // R10: outputs are low in the cycle after a reset edge.
  a_r10_reset_low: assert property (@(posedge clk)
    !$past(rst_n) |-> (hi_en_o == '0 && lo_en_o == '0));
endmodule

// File: tb/test_hall_commutator.sv
`timescale 1ns/1ps
module test_hall_commutator;
  localparam int DEAD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       dir = 1'b0;
  logic       brk_n = 1'b1;
  logic       stop = 1'b1;
  logic       pwm = 1'b1;
  logic [2:0] hi_en, lo_en;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hall_commutator #(.DEAD_CYC(DEAD)) i_hall_commutator (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_i(dir),
    .brake_n_i(brk_n), .stop_i(stop), .pwm_i(pwm),
    .hi_en_o(hi_en), .lo_en_o(lo_en)
  );

  // Expected pair from R1/R2: {hi, lo}, bit 0 = U.
  function automatic logic [5:0] pair(input logic [2:0] code, input logic d);
    logic [2:0] c;
    c = d ? ~code : code;
    case (c)
      3'b101:  return {3'b010, 3'b001};
      3'b100:  return {3'b100, 3'b001};
      3'b110:  return {3'b100, 3'b010};
      3'b010:  return {3'b001, 3'b010};
      3'b011:  return {3'b001, 3'b100};
      3'b001:  return {3'b010, 3'b100};
      default: return 6'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    total++;
    if ({hi_en, lo_en} !== exp) begin
      bad++;
      $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b",
               req, hi_en, lo_en, exp[5:3], exp[2:0]);
    end
  endtask

  // Change inputs just after a falling edge, then wait n falling edges.
  task automatic drive(input logic [2:0] h, input logic d, input logic bn,
                       input logic s, input logic p, input int n);
    @(negedge clk);
    hall = h; dir = d; brk_n = bn; stop = s; pwm = p;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_n(3);
    check("R10 reset", 6'b0);
    rst_n = 1'b1;
    wait_n(3);
    check("R6 stop held after reset", 6'b0);
  endtask

  task automatic t_forward;
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    drive(3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    foreach (seq[i]) begin
      drive(seq[i], 1'b0, 1'b1, 1'b0, 1'b1, 2);
      check("R1 forward code", pair(seq[i], 1'b0));
    end
  endtask

  task automatic t_reverse;
    logic [2:0] seq [6] = '{3'b010, 3'b011, 3'b001, 3'b101, 3'b100, 3'b110};
    drive(3'b010, 1'b1, 1'b1, 1'b1, 1'b1, 2);
    foreach (seq[i]) begin
      drive(seq[i], 1'b1, 1'b1, 1'b0, 1'b1, 2);
      check("R2 reverse code", pair(seq[i], 1'b1));
    end
    drive(3'b010, 1'b1, 1'b1, 1'b1, 1'b1, 2);
    drive(3'b010, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    check("R2 010 gives V high U low", {3'b010, 3'b001});
  endtask

  task automatic t_pwm;
    drive(3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    drive(3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 2);
    check("R3 chop off keeps low side", {3'b000, 3'b001});
    drive(3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    check("R3 chop on", {3'b010, 3'b001});
  endtask

  task automatic t_invalid;
    drive(3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    check("R4 code 000", 6'b0);
    drive(3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    check("R4 code 111", 6'b0);
  endtask

  task automatic t_brake_stop;
    drive(3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    drive(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    check("R5 R7 brake over invalid, unchopped", {3'b111, 3'b000});
    drive(3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 2);
    check("R7 brake over valid code", {3'b111, 3'b000});
    drive(3'b110, 1'b0, 1'b0, 1'b1, 1'b1, 2);
    check("R6 stop over brake", 6'b0);
  endtask

  task automatic t_commutate_latency;
    drive(3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    drive(3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    drive(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1);
    check("R9 old pattern after one edge", {3'b010, 3'b001});
    wait_n(1);
    check("R9 new pattern after two edges", {3'b100, 3'b001});
  endtask

  task automatic t_dead_dir;
    drive(3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    drive(3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    check("R8 settle before flip", {3'b010, 3'b001});
    drive(3'b101, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    check("R8 dir flip off at edge 2", 6'b0);
    wait_n(DEAD);
    check("R8 dir flip still off at last dead edge", 6'b0);
    wait_n(1);
    check("R8 dir flip new pattern", {3'b001, 3'b010});
  endtask

  task automatic t_dead_brake;
    drive(3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    drive(3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    drive(3'b101, 1'b0, 1'b0, 1'b0, 1'b1, DEAD + 2);
    check("R8 brake entry still off", 6'b0);
    wait_n(1);
    check("R8 brake entry applied", {3'b111, 3'b000});
    drive(3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    check("R8 brake exit off", 6'b0);
    wait_n(DEAD + 1);
    check("R8 brake exit new pattern", {3'b010, 3'b001});
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_pwm();
    t_invalid();
    t_brake_stop();
    t_commutate_latency();
    t_dead_dir();
    t_dead_brake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule